// File: doc/BRIEF.md
# Serial port interrupt and DMA-request unit

This unit holds the control and status registers of a multi-format synchronous serial port and turns FIFO fill levels into interrupt and DMA-request signalling. The two FIFOs report their fill levels in bytes. The unit converts each level into whole samples, using the sample width programmed in control register 1. It then compares each sample count against a threshold taken from the interrupt-enable register. The resulting flags, together with sticky underrun and overrun events, drive a single level interrupt and one DMA request line per direction.

Each DMA request follows a request/acknowledge handshake. A request rises when its threshold condition holds and stays high until it is acknowledged. On the acknowledge cycle, the request is re-evaluated: it stays high if the condition still holds and drops otherwise. Software reads the interrupt status register to clear the event bits. The threshold bits follow the live fill levels. While the port enable bit is clear, the flags and requests freeze.

Register access uses a plain single-cycle bus. A write takes effect at the clock edge. Read data is combinational from the current register state. There is no back-pressure: every access completes in the cycle it is presented. The serial shifters and the FIFO storage sit outside this unit.

Top module: `sport_irq_dma`

## Requirements
- R1: After reset, the following hold: interrupt-enable (0x10) reads 0x00002200, interrupt status (0x14) reads 0x00000008, control registers 0x00/0x04/0x08 read 0, `irq` is low and both DMA requests are low.
- R2: Control0 (0x00), control1 (0x04), control2 (0x08) and interrupt-enable (0x10) store all 32 written bits and read them back. Writes to 0x0C, 0x14, 0x18, 0x60 and 0x64 change nothing. Version (0x60) reads 0x00010300. Feature (0x64) reads {16'h0, FIFO_SAMPLES[7:0], OCC_W[7:0]}, which is 0x00001007 by default. The data register 0x18 and unmapped addresses read 0.
- R3: Bytes per sample are floor((control1[21:16]+1)/8), with a minimum of 1. The sample count is floor(byte level / bytes per sample). Status (0x0C) reads as follows: transmit samples saturated to 31 in bits 16:12, receive samples saturated to 31 in bits 8:4, `port_busy` in bit 2, NOT `tx_full` in bit 1, `rx_full` in bit 0, and 0 elsewhere.
- R4: While control2 bit 0 is set, each clock edge loads interrupt-status bit 3 with (transmit samples <= interrupt-enable[16:12]).
- R5: While control2 bit 0 is set, each clock edge loads interrupt-status bit 2 with (receive samples >= interrupt-enable[11:7]). When control0[14:12] equals 3'b001, this bit is loaded with 1 regardless of the receive level.
- R6: A `rx_overrun` pulse sets status bit 0 and a `tx_underrun` pulse sets status bit 1. Both bits stay set until a read of 0x14, which returns the current value and then clears bits 0 and 1. A pulse arriving in the same cycle as that read leaves its bit set.
- R7: `irq` is high exactly when some bit in status[3:0] AND interrupt-enable[3:0] is set.
- R8: Interrupt-enable bit 5 enables the transmit request and bit 4 enables the receive request. A disabled request is low one cycle later. An enabled request rises with its threshold condition and holds until it is acknowledged. On an acknowledge, its next value equals the condition.
- R9: While control2 bit 0 is clear, the threshold bits, the event bits and the enabled DMA requests hold their values, and event pulses are ignored. A status read still clears bits 0 and 1, and a disabled DMA request still drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status events at the edge) |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| tx_level | input | OCC_W | Transmit FIFO level in bytes |
| rx_level | input | OCC_W | Receive FIFO level in bytes |
| tx_full | input | 1 | Transmit FIFO full |
| rx_full | input | 1 | Receive FIFO full |
| port_busy | input | 1 | Shifter busy |
| tx_underrun | input | 1 | Single-cycle transmit underrun event |
| rx_overrun | input | 1 | Single-cycle receive overrun event |
| tx_dma_ack | input | 1 | Transmit DMA acknowledge |
| rx_dma_ack | input | 1 | Receive DMA acknowledge |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_dma_req | output | 1 | Receive DMA request |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take for granted only that the inputs are valid at each rising edge. Event pulses and acknowledges may arrive in any cycle, including on top of a status read or while the port is disabled. FIFO levels may take any value of their width, even values beyond the FIFO depth. The stimulus therefore draws levels across and above the saturation point and fires events and acknowledges at random rates. It also writes the control registers with random contents, keeping the port enabled most of the time. Directed sequences add the coinciding read-and-event case, acknowledge with and without a standing condition, the forced receive format, and writes to read-only addresses.

// File: rtl/sport_pkg.sv
package sport_pkg;

  localparam int unsigned REG_AW = 8;
  localparam int unsigned REG_DW = 32;

  localparam logic [REG_AW-1:0] A_CTL0 = 8'h00;
  localparam logic [REG_AW-1:0] A_CTL1 = 8'h04;
  localparam logic [REG_AW-1:0] A_CTL2 = 8'h08;
  localparam logic [REG_AW-1:0] A_STAT = 8'h0C;
  localparam logic [REG_AW-1:0] A_IEN  = 8'h10;
  localparam logic [REG_AW-1:0] A_IST  = 8'h14;
  localparam logic [REG_AW-1:0] A_DATA = 8'h18;
  localparam logic [REG_AW-1:0] A_VER  = 8'h60;
  localparam logic [REG_AW-1:0] A_FEAT = 8'h64;

  localparam int unsigned IST_ORUN = 0;
  localparam int unsigned IST_URUN = 1;
  localparam int unsigned IST_RXTH = 2;
  localparam int unsigned IST_TXTH = 3;
  localparam int unsigned IST_W    = 4;

  localparam logic [REG_DW-1:0] IEN_RST = 32'h0000_2200;
  localparam logic [IST_W-1:0]  IST_RST = 4'b1000;
  localparam logic [2:0]        FMT_RX_FORCED = 3'b001;
  localparam int unsigned       THR_W = 5;

  typedef struct packed {
    logic             port_en;
    logic             rx_forced;
    logic [5:0]       width_m1;
    logic [THR_W-1:0] tx_thr;
    logic [THR_W-1:0] rx_thr;
    logic             tx_dma_en;
    logic             rx_dma_en;
    logic [IST_W-1:0] irq_mask;
  } sport_cfg_t;

endpackage

// File: rtl/sport_occ.sv
module sport_occ #(
  parameter int unsigned OCC_W = 7
) (
  input  logic [5:0]       width_m1,
  input  logic [OCC_W-1:0] bytes_lvl,
  output logic [OCC_W-1:0] samples,
  output logic [4:0]       samples_sat
);
  logic [3:0] bytes_per_smp;
  logic [3:0] bps;

  assign bytes_per_smp = 4'((7'(width_m1) + 7'd1) >> 3);
  assign bps           = (bytes_per_smp == 4'd0) ? 4'd1 : bytes_per_smp;
  assign samples       = bytes_lvl / OCC_W'(bps);
  assign samples_sat   = (samples > OCC_W'(31)) ? 5'd31 : samples[4:0];

endmodule

// File: rtl/sport_regs.sv
module sport_regs
  import sport_pkg::*;
#(
  parameter logic [REG_DW-1:0] VERSION = 32'h0001_0300,
  parameter logic [REG_DW-1:0] FEATURE = 32'h0000_1007
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [REG_DW-1:0] wdata,
  output logic [REG_DW-1:0] rdata,
  input  logic [IST_W-1:0]  ist,
  input  logic [4:0]        tx_sat,
  input  logic [4:0]        rx_sat,
  input  logic              busy,
  input  logic              tx_full,
  input  logic              rx_full,
  output sport_cfg_t        cfg,
  output logic              ist_rd_clr
);
  logic [REG_DW-1:0] ctl0_q, ctl1_q, ctl2_q, ien_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl0_q <= '0;
      ctl1_q <= '0;
      ctl2_q <= '0;
      ien_q  <= IEN_RST;
    end else if (wr_en) begin
      case (addr)
        A_CTL0:  ctl0_q <= wdata;
        A_CTL1:  ctl1_q <= wdata;
        A_CTL2:  ctl2_q <= wdata;
        A_IEN:   ien_q  <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr)
      A_CTL0:  rdata = ctl0_q;
      A_CTL1:  rdata = ctl1_q;
      A_CTL2:  rdata = ctl2_q;
      A_STAT:  rdata = {15'd0, tx_sat, 3'd0, rx_sat, 1'b0, busy, ~tx_full, rx_full};
      A_IEN:   rdata = ien_q;
      A_IST:   rdata = {{(REG_DW-IST_W){1'b0}}, ist};
      A_VER:   rdata = VERSION;
      A_FEAT:  rdata = FEATURE;
      default: rdata = '0;
    endcase
  end

  assign ist_rd_clr = rd_en && (addr == A_IST);

  always_comb begin
    cfg.port_en   = ctl2_q[0];
    cfg.rx_forced = (ctl0_q[14:12] == FMT_RX_FORCED);
    cfg.width_m1  = ctl1_q[21:16];
    cfg.tx_thr    = ien_q[16:12];
    cfg.rx_thr    = ien_q[11:7];
    cfg.tx_dma_en = ien_q[5];
    cfg.rx_dma_en = ien_q[4];
    cfg.irq_mask  = ien_q[IST_W-1:0];
  end

  AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_STAT || addr == A_IST || addr == A_DATA || addr == A_VER || addr == A_FEAT))
    |=> ($stable(ctl0_q) && $stable(ctl1_q) && $stable(ctl2_q) && $stable(ien_q))); // R2

  AST_IEN_ONLY_BY_ITS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_IEN) |=> $stable(ien_q)); // R2

endmodule

// File: rtl/sport_isr.sv
module sport_isr
  import sport_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             tx_cond,
  input  logic             rx_cond,
  input  logic             urun,
  input  logic             orun,
  input  logic             rd_clr,
  input  logic [IST_W-1:0] irq_mask,
  output logic [IST_W-1:0] ist,
  output logic             irq
);
  logic [IST_W-1:0] ist_q, ist_d;

  always_comb begin
    ist_d = ist_q;
    if (rd_clr) begin
      ist_d[IST_ORUN] = 1'b0;
      ist_d[IST_URUN] = 1'b0;
    end
    if (en) begin
      ist_d[IST_TXTH] = tx_cond;
      ist_d[IST_RXTH] = rx_cond;
      if (orun) ist_d[IST_ORUN] = 1'b1;
      if (urun) ist_d[IST_URUN] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ist_q <= IST_RST;
    else        ist_q <= ist_d;
  end

  assign ist = ist_q;
  assign irq = |(ist_q & irq_mask);

  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rd_clr) |=> $stable(ist_q)); // R9

  AST_ORUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && orun) |=> ist_q[IST_ORUN]); // R6

  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(en && urun)) |=> !ist_q[IST_URUN]); // R6

  AST_TX_FLAG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (ist_q[IST_TXTH] == $past(tx_cond))); // R4

endmodule

// File: rtl/sport_dma.sv
module sport_dma (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic dma_en,
  input  logic cond,
  input  logic ack,
  output logic req
);
  logic req_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      req_q <= 1'b0;
    else if (!dma_en) req_q <= 1'b0;
    else if (en)     req_q <= ack ? cond : (req_q | cond);
  end

  assign req = req_q;

  AST_REQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_en |=> !req_q); // R8

  AST_REQ_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_en && ack && cond) |=> req_q); // R8

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && dma_en && ack && !cond) |=> !req_q); // R8

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_en && req_q && !ack) |=> req_q); // R8

endmodule

// File: rtl/sport_irq_dma.sv
module sport_irq_dma
  import sport_pkg::*;
#(
  parameter int unsigned       OCC_W        = 7,
  parameter int unsigned       FIFO_SAMPLES = 16,
  parameter logic [REG_DW-1:0] VERSION      = 32'h0001_0300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic [OCC_W-1:0]  tx_level,
  input  logic [OCC_W-1:0]  rx_level,
  input  logic              tx_full,
  input  logic              rx_full,
  input  logic              port_busy,
  input  logic              tx_underrun,
  input  logic              rx_overrun,
  input  logic              tx_dma_ack,
  input  logic              rx_dma_ack,
  output logic              tx_dma_req,
  output logic              rx_dma_req,
  output logic              irq
);
  localparam int unsigned NDIR = 2;
  localparam logic [REG_DW-1:0] FEATURE = {16'h0, 8'(FIFO_SAMPLES), 8'(OCC_W)};

  sport_cfg_t       cfg;
  logic [IST_W-1:0] ist;
  logic             ist_rd_clr;

  logic [NDIR-1:0][OCC_W-1:0] lvl_bytes;
  logic [NDIR-1:0][OCC_W-1:0] lvl_smp;
  logic [NDIR-1:0][4:0]       lvl_sat;
  logic [NDIR-1:0]            cond;
  logic [NDIR-1:0]            dma_en;
  logic [NDIR-1:0]            ack;
  logic [NDIR-1:0]            req;

  assign lvl_bytes[0] = tx_level;
  assign lvl_bytes[1] = rx_level;
  assign dma_en       = {cfg.rx_dma_en, cfg.tx_dma_en};
  assign ack          = {rx_dma_ack, tx_dma_ack};

  assign cond[0] = lvl_smp[0] <= OCC_W'(cfg.tx_thr);
  assign cond[1] = cfg.rx_forced || (lvl_smp[1] >= OCC_W'(cfg.rx_thr));

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    sport_occ #(.OCC_W(OCC_W)) u_occ (
      .width_m1    (cfg.width_m1),
      .bytes_lvl   (lvl_bytes[g]),
      .samples     (lvl_smp[g]),
      .samples_sat (lvl_sat[g])
    );

    sport_dma u_dma (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (cfg.port_en),
      .dma_en (dma_en[g]),
      .cond   (cond[g]),
      .ack    (ack[g]),
      .req    (req[g])
    );
  end

  sport_regs #(.VERSION(VERSION), .FEATURE(FEATURE)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (reg_wr),
    .rd_en      (reg_rd),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .ist        (ist),
    .tx_sat     (lvl_sat[0]),
    .rx_sat     (lvl_sat[1]),
    .busy       (port_busy),
    .tx_full    (tx_full),
    .rx_full    (rx_full),
    .cfg        (cfg),
    .ist_rd_clr (ist_rd_clr)
  );

  sport_isr u_isr (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.port_en),
    .tx_cond  (cond[0]),
    .rx_cond  (cond[1]),
    .urun     (tx_underrun),
    .orun     (rx_overrun),
    .rd_clr   (ist_rd_clr),
    .irq_mask (cfg.irq_mask),
    .ist      (ist),
    .irq      (irq)
  );

  assign tx_dma_req = req[0];
  assign rx_dma_req = req[1];

  AST_RX_FORCED_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.port_en && cfg.rx_forced) |=> ist[IST_RXTH]); // R5

endmodule

// File: tb/tb_sport_irq_dma.sv
`timescale 1ns/1ps
module tb_sport_irq_dma;
  localparam int OW = 7;
  localparam logic [31:0] VER  = 32'h0001_0300;
  localparam logic [31:0] FEAT = 32'h0000_1007;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 0, reg_rd = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic [OW-1:0] tx_level = 0, rx_level = 0;
  logic tx_full = 0, rx_full = 0, port_busy = 0;
  logic tx_underrun = 0, rx_overrun = 0, tx_dma_ack = 0, rx_dma_ack = 0;
  logic tx_dma_req, rx_dma_req, irq;

  always #2 clk = ~clk;

  sport_irq_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_level(tx_level), .rx_level(rx_level),
    .tx_full(tx_full), .rx_full(rx_full), .port_busy(port_busy), .tx_underrun(tx_underrun),
    .rx_overrun(rx_overrun), .tx_dma_ack(tx_dma_ack), .rx_dma_ack(rx_dma_ack),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req), .irq(irq));

  int nchk = 0, nerr = 0;
  bit done = 0;
  bit in_reset_phase = 0;

  logic [31:0] m_c0, m_c1, m_c2, m_ien;
  logic [3:0]  m_ist;
  logic        m_rtx, m_rrx;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int bps_of(input logic [31:0] c1);
    int b;
    b = (int'(c1[21:16]) + 1) >> 3;
    return (b == 0) ? 1 : b;
  endfunction

  function automatic int smp(input logic [OW-1:0] lvl);
    return int'(lvl) / bps_of(m_c1);
  endfunction

  function automatic logic [4:0] sat5(input int v);
    return (v > 31) ? 5'd31 : v[4:0];
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    case (a)
      8'h00: return m_c0;
      8'h04: return m_c1;
      8'h08: return m_c2;
      8'h0C: return {15'd0, sat5(smp(tx_level)), 3'd0, sat5(smp(rx_level)), 1'b0,
                     port_busy, ~tx_full, rx_full};
      8'h10: return m_ien;
      8'h14: return {28'd0, m_ist};
      8'h60: return VER;
      8'h64: return FEAT;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [7:0] a);
    if (in_reset_phase) return "R1";
    case (a)
      8'h0C: return "R3";
      8'h14: return "R4/R5/R6/R9";
      default: return "R2";
    endcase
  endfunction

  task automatic model_reset();
    m_c0 = 0; m_c1 = 0; m_c2 = 0; m_ien = 32'h0000_2200; m_ist = 4'b1000;
    m_rtx = 0; m_rrx = 0;
  endtask

  task automatic cyc(input bit wr, input bit rd, input logic [7:0] a, input logic [31:0] d);
    bit en, txc, rxc, ntx, nrx;
    logic [3:0] ni;
    @(negedge clk);
    reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = d;
    #1;
    chk("R7 irq", {31'd0, irq}, {31'd0, |(m_ist & m_ien[3:0])});
    chk("R8/R9 tx_req", {31'd0, tx_dma_req}, {31'd0, m_rtx});
    chk("R8/R9 rx_req", {31'd0, rx_dma_req}, {31'd0, m_rrx});
    if (rd) chk(tag_of(a), reg_rdata, exp_read(a));
    en  = m_c2[0];
    txc = smp(tx_level) <= int'(m_ien[16:12]);
    rxc = (m_c0[14:12] == 3'b001) || (smp(rx_level) >= int'(m_ien[11:7]));
    ni = m_ist;
    if (rd && a == 8'h14) ni[1:0] = 2'b00;
    if (en) begin
      ni[3] = txc; ni[2] = rxc;
      if (rx_overrun) ni[0] = 1'b1;
      if (tx_underrun) ni[1] = 1'b1;
    end
    ntx = m_rtx; nrx = m_rrx;
    if (!m_ien[5]) ntx = 0; else if (en) ntx = tx_dma_ack ? txc : (m_rtx | txc);
    if (!m_ien[4]) nrx = 0; else if (en) nrx = rx_dma_ack ? rxc : (m_rrx | rxc);
    @(posedge clk);
    m_ist = ni; m_rtx = ntx; m_rrx = nrx;
    if (wr) case (a)
      8'h00: m_c0 = d;
      8'h04: m_c1 = d;
      8'h08: m_c2 = d;
      8'h10: m_ien = d;
      default: ;
    endcase
    #1;
    reg_wr = 0; reg_rd = 0; tx_underrun = 0; rx_overrun = 0; tx_dma_ack = 0; rx_dma_ack = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [7:0] addrs [9];
    addrs = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h60, 8'h64};
    void'($urandom(32'd4242));
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset values
    in_reset_phase = 1;
    cyc(0, 1, 8'h00, 0); cyc(0, 1, 8'h04, 0); cyc(0, 1, 8'h08, 0);
    cyc(0, 1, 8'h10, 0); cyc(0, 1, 8'h14, 0);
    in_reset_phase = 0;

    // R2: read-only addresses ignore writes, constants
    foreach (addrs[i]) cyc(1, 0, addrs[i], 32'hFFFF_FFFF);
    foreach (addrs[i]) cyc(0, 1, addrs[i], 0);

    // R3: width of 32 bits -> 4 bytes/sample, 40 bytes -> 10 samples
    cyc(1, 0, 8'h04, 32'h001F_0000);
    tx_level = 40; rx_level = 7; port_busy = 1; tx_full = 1;
    cyc(0, 1, 8'h0C, 0);
    port_busy = 0; tx_full = 0;

    // R4/R6/R7: enable port and all interrupts, event pulses
    cyc(1, 0, 8'h10, 32'h0000_300F);
    cyc(1, 0, 8'h08, 32'h1);
    rx_overrun = 1; cyc(0, 0, 8'h00, 0);
    cyc(0, 1, 8'h14, 0);
    cyc(0, 1, 8'h14, 0);
    tx_underrun = 1; cyc(0, 1, 8'h14, 0);   // R6 pulse coinciding with read
    cyc(0, 1, 8'h14, 0);

    // R8: tx DMA with ack while condition holds, then without
    cyc(1, 0, 8'h10, 32'h0000_5020);
    tx_level = 0; cyc(0, 0, 8'h00, 0);
    tx_dma_ack = 1; cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 0);
    tx_level = 120; tx_dma_ack = 1; cyc(0, 0, 8'h00, 0);
    cyc(0, 0, 8'h00, 0);

    // R5: forced receive format
    cyc(1, 0, 8'h10, 32'h0000_0F90);
    rx_level = 0; cyc(1, 0, 8'h00, 32'h0000_1000);
    cyc(0, 0, 8'h00, 0); cyc(0, 1, 8'h14, 0);

    // R9: port disabled freezes flags, events, requests
    cyc(1, 0, 8'h08, 32'h0);
    rx_overrun = 1; tx_level = 0; rx_level = 0; rx_dma_ack = 1;
    cyc(0, 0, 8'h00, 0); cyc(0, 1, 8'h14, 0); cyc(0, 1, 8'h14, 0);
    cyc(1, 0, 8'h08, 32'h1);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      int op;
      logic [7:0] a;
      logic [31:0] d;
      tx_level = OW'($urandom_range(0, 90));
      rx_level = OW'($urandom_range(0, 90));
      tx_full = ($urandom % 4) == 0; rx_full = ($urandom % 4) == 0;
      port_busy = $urandom % 2;
      tx_underrun = ($urandom % 8) == 0; rx_overrun = ($urandom % 8) == 0;
      tx_dma_ack = ($urandom % 4) == 0; rx_dma_ack = ($urandom % 4) == 0;
      op = $urandom % 10;
      a = addrs[$urandom % 9];
      d = $urandom;
      if (a == 8'h08) d[0] = ($urandom % 5) != 0;
      if (a == 8'h00 && ($urandom % 2)) d[14:12] = 3'b001;
      if (op < 2) cyc(1, 0, a, d);
      else if (op < 6) cyc(0, 1, a, 0);
      else cyc(0, 0, 8'h00, 0);
    end
    finish_run();
  end
endmodule